// File: doc/BRIEF.md
# Large-Core Bottleneck Request Queue

This block sits in front of one large core and holds bottleneck requests that small cores have migrated to it. A request carries a bottleneck identifier, the program counter where the bottleneck starts, the caller's stack pointer and the number of the small core that sent it. Each request also has a priority: the number of thread-waiting cycles that its bottleneck has accumulated. The block has one slot for each small core.

When the large core reports that it is idle and nothing is running, the block issues the waiting request with the largest waiting-cycle count. If two counts are equal, the lower slot wins. The large core then ends the running request in one of two ways. It can report completion, which frees the slot and notifies the source core. It can also report that the request cannot make progress. In that case the block frees the slot and hands the whole request back to its source core, so that independent requests queued behind it are not held up.

Waiting-cycle counts are refreshed through an update port that is keyed by bottleneck identifier. One update rewrites every queued entry that carries that identifier.

Top module: `bneck_sched_buf`

## Requirements
- R1: After reset no entry is held, `enq_ready` is 1, and `iss_valid` and `ret_valid` are 0.
- R2: A request is stored when `enq_valid` and `enq_ready` are both 1. Once NUM_SRC entries are held, `enq_ready` is 0, and a request offered while full is discarded and never issued.
- R3: A request is issued only in a cycle where `lc_idle` is 1 and no request is running. `iss_valid` is a one-cycle pulse in the cycle after that edge, carrying the id, pc, sp and source core of the request.
- R4: The issued request is the waiting entry with the largest priority value.
- R5: Each request is stored in the lowest free slot index. Among waiting entries of equal priority, the one in the lowest slot is issued.
- R6: At most one request runs at a time. No further issue occurs until the running request ends with `lc_done` or `lc_block`.
- R7: `lc_done` while a request runs frees its slot. One cycle later `ret_valid` pulses with `ret_kind` = 0, the source core and the id.
- R8: `lc_block` while a request runs frees its slot. One cycle later `ret_valid` pulses with `ret_kind` = 1 and the request's id, pc, sp and source core, which returns the request to that core.
- R9: A priority update (`upd_valid`) rewrites the priority of every held entry whose id equals `upd_id`, and the next selection uses the new value.
- R10: `lc_done` or `lc_block` arriving while no request runs has no effect: `ret_valid` stays 0.
- R11: A freed slot can be used again. `enq_ready` returns to 1 in the cycle after a full buffer frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | A small core offers a request |
| enq_ready | output | 1 | A free slot exists |
| enq_id | input | ID_W | Bottleneck identifier |
| enq_pc | input | PC_W | Bottleneck start address |
| enq_sp | input | SP_W | Caller stack pointer |
| enq_src | input | $clog2(NUM_SRC) | Requesting small core |
| enq_prio | input | PRIO_W | Initial waiting-cycle count |
| upd_valid | input | 1 | Priority update strobe |
| upd_id | input | ID_W | Identifier whose entries are updated |
| upd_prio | input | PRIO_W | New waiting-cycle count |
| lc_idle | input | 1 | Large core can accept a request |
| lc_done | input | 1 | Running request finished |
| lc_block | input | 1 | Running request cannot progress |
| iss_valid | output | 1 | Issue pulse to the large core |
| iss_id | output | ID_W | Issued identifier |
| iss_pc | output | PC_W | Issued start address |
| iss_sp | output | SP_W | Issued stack pointer |
| iss_src | output | $clog2(NUM_SRC) | Issued source core |
| ret_valid | output | 1 | Notification to a small core |
| ret_kind | output | 1 | 0 = finished, 1 = sent back |
| ret_id | output | ID_W | Identifier of the ended request |
| ret_pc | output | PC_W | Start address, for a resend |
| ret_sp | output | SP_W | Stack pointer, for a resend |
| ret_src | output | $clog2(NUM_SRC) | Core that receives the notification |

## Verification
Some rules are checked by the assertions on every cycle. Issue pulses last one cycle and happen only after the core was idle. A notification always follows a running request. A refused request while full leaves the occupancy unchanged. The selector never picks an entry that another waiting entry outranks. Other behaviour shows only in the bench's scenarios: the exact issue order for mixed and tied priorities, the fields carried on a send-back, the effect of an identifier-keyed update on duplicate entries, and the discarding of a request offered while full.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  typedef enum logic {
    RET_DONE    = 1'b0,
    RET_BLOCKED = 1'b1
  } ret_kind_e;
endpackage

// File: rtl/bsb_alloc.sv
module bsb_alloc #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     used,
  output logic             full,
  output logic [IDX_W-1:0] free_idx
);
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) free_idx = IDX_W'(i);
    end
  end

  assign full = &used;
endmodule

// File: rtl/bsb_prio_sel.sv
module bsb_prio_sel #(
  parameter int N      = 4,
  parameter int PRIO_W = 16,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]      cand,
  input  logic [PRIO_W-1:0] prio [N],
  output logic              found,
  output logic [IDX_W-1:0]  sel_idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i] > best)) begin
        found   = 1'b1;
        sel_idx = IDX_W'(i);
        best    = prio[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      // R4 R5
      sel_max_chk: assert (!(found && cand[i]) ||
                           (prio[i] < prio[sel_idx]) ||
                           (prio[i] == prio[sel_idx] && IDX_W'(i) >= sel_idx));
    end
  end
endmodule

// File: rtl/bneck_sched_buf.sv
module bneck_sched_buf #(
  parameter int NUM_SRC = 4,
  parameter int ID_W    = 8,
  parameter int PC_W    = 32,
  parameter int SP_W    = 32,
  parameter int PRIO_W  = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [ID_W-1:0]   enq_id,
  input  logic [PC_W-1:0]   enq_pc,
  input  logic [SP_W-1:0]   enq_sp,
  input  logic [IDX_W-1:0]  enq_src,
  input  logic [PRIO_W-1:0] enq_prio,
  input  logic              upd_valid,
  input  logic [ID_W-1:0]   upd_id,
  input  logic [PRIO_W-1:0] upd_prio,
  input  logic              lc_idle,
  input  logic              lc_done,
  input  logic              lc_block,
  output logic              iss_valid,
  output logic [ID_W-1:0]   iss_id,
  output logic [PC_W-1:0]   iss_pc,
  output logic [SP_W-1:0]   iss_sp,
  output logic [IDX_W-1:0]  iss_src,
  output logic              ret_valid,
  output logic              ret_kind,
  output logic [ID_W-1:0]   ret_id,
  output logic [PC_W-1:0]   ret_pc,
  output logic [SP_W-1:0]   ret_sp,
  output logic [IDX_W-1:0]  ret_src
);
  import bsb_pkg::*;

  logic [NUM_SRC-1:0] held_q, run_q;
  logic [ID_W-1:0]    id_q   [NUM_SRC];
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [IDX_W-1:0]   src_q  [NUM_SRC];
  logic [PC_W-1:0]    pc_mem [NUM_SRC];
  logic [SP_W-1:0]    sp_mem [NUM_SRC];

  logic             full, found, busy, do_enq, do_issue, do_free;
  logic [IDX_W-1:0] free_idx, sel_idx, run_idx;
  ret_kind_e        ret_kind_q;

  bsb_alloc #(.N(NUM_SRC), .IDX_W(IDX_W)) alloc_i (
    .used(held_q), .full(full), .free_idx(free_idx)
  );

  bsb_prio_sel #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) sel_i (
    .cand(held_q & ~run_q), .prio(prio_q), .found(found), .sel_idx(sel_idx)
  );

  always_comb begin
    run_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (run_q[i]) run_idx = IDX_W'(i);
    end
  end

  assign busy      = |run_q;
  assign enq_ready = !full;
  assign do_enq    = enq_valid && !full;
  assign do_issue  = lc_idle && !busy && found;
  assign do_free   = busy && (lc_done || lc_block);

  // control and small per-entry fields
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= '0;
      run_q      <= '0;
      iss_valid  <= 1'b0;
      ret_valid  <= 1'b0;
      ret_kind_q <= RET_DONE;
    end else begin
      iss_valid <= do_issue;
      ret_valid <= do_free;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (upd_valid && held_q[i] && id_q[i] == upd_id) prio_q[i] <= upd_prio;
      end
      if (do_issue) begin
        run_q[sel_idx] <= 1'b1;
        iss_id         <= id_q[sel_idx];
        iss_src        <= src_q[sel_idx];
      end
      if (do_free) begin
        held_q[run_idx] <= 1'b0;
        run_q[run_idx]  <= 1'b0;
        ret_kind_q      <= lc_block ? RET_BLOCKED : RET_DONE;
        ret_id          <= id_q[run_idx];
        ret_src         <= src_q[run_idx];
      end
      if (do_enq) begin
        held_q[free_idx] <= 1'b1;
        id_q[free_idx]   <= enq_id;
        prio_q[free_idx] <= enq_prio;
        src_q[free_idx]  <= enq_src;
      end
    end
  end

  // wide payload: one write port, registered reads, no reset
  always_ff @(posedge clk) begin
    if (do_enq) begin
      pc_mem[free_idx] <= enq_pc;
      sp_mem[free_idx] <= enq_sp;
    end
    if (do_issue) begin
      iss_pc <= pc_mem[sel_idx];
      iss_sp <= sp_mem[sel_idx];
    end
    if (do_free) begin
      ret_pc <= pc_mem[run_idx];
      ret_sp <= sp_mem[run_idx];
    end
  end

  assign ret_kind = ret_kind_q;

  // R6
  single_issue_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> !iss_valid);

  // R3
  issue_idle_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> $past(lc_idle));

  // R10
  ret_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !ret_valid);

  // R7 R8
  ret_follows_run_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(busy));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && !enq_ready && !lc_done && !lc_block)
      |=> $countones(held_q) == $past($countones(held_q)));
endmodule

// File: tb/bneck_sched_buf_tb.sv
module bneck_sched_buf_tb_top;
  localparam int N = 4, IW = 8, PW = 32, SW = 32, QW = 16, XW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic enq_valid = 0, upd_valid = 0, lc_idle = 0, lc_done = 0, lc_block = 0;
  logic [IW-1:0] enq_id = 0, upd_id = 0;
  logic [PW-1:0] enq_pc = 0;
  logic [SW-1:0] enq_sp = 0;
  logic [XW-1:0] enq_src = 0;
  logic [QW-1:0] enq_prio = 0, upd_prio = 0;
  logic enq_ready, iss_valid, ret_valid, ret_kind;
  logic [IW-1:0] iss_id, ret_id;
  logic [PW-1:0] iss_pc, ret_pc;
  logic [SW-1:0] iss_sp, ret_sp;
  logic [XW-1:0] iss_src, ret_src;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bneck_sched_buf #(.NUM_SRC(N), .ID_W(IW), .PC_W(PW), .SP_W(SW), .PRIO_W(QW)) dut_i (
    .clk, .rst, .enq_valid, .enq_ready, .enq_id, .enq_pc, .enq_sp, .enq_src,
    .enq_prio, .upd_valid, .upd_id, .upd_prio, .lc_idle, .lc_done, .lc_block,
    .iss_valid, .iss_id, .iss_pc, .iss_sp, .iss_src, .ret_valid, .ret_kind,
    .ret_id, .ret_pc, .ret_sp, .ret_src
  );

  // stimulus table: id, src, prio; expected issue order as row numbers
  localparam int T_ID[4]   = '{10, 11, 12, 13};
  localparam int T_SRC[4]  = '{0, 1, 2, 3};
  localparam int T_PRIO[4] = '{5, 9, 9, 1};
  localparam int T_ORD[4]  = '{1, 2, 0, 3};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enq(input int id, input int src, input int prio);
    enq_valid = 1; enq_id = IW'(id); enq_src = XW'(src); enq_prio = QW'(prio);
    enq_pc = PW'(32'h1000 + id); enq_sp = SW'(32'h8000 + id);
    tick();
    enq_valid = 0;
  endtask

  task automatic issue(input string req, input int id, input int src);
    lc_idle = 1;
    tick();
    lc_idle = 0;
    chk({req, " iss_valid"}, iss_valid, 1);
    chk({req, " iss_id"}, iss_id, id);
    chk({req, " iss_src"}, iss_src, src);
    chk({req, " iss_pc"}, iss_pc, 32'h1000 + id);
    chk({req, " iss_sp"}, iss_sp, 32'h8000 + id);
  endtask

  task automatic finish_run(input string req, input bit blk, input int id, input int src);
    lc_done = !blk; lc_block = blk;
    tick();
    lc_done = 0; lc_block = 0;
    chk({req, " ret_valid"}, ret_valid, 1);
    chk({req, " ret_kind"}, ret_kind, blk);
    chk({req, " ret_id"}, ret_id, id);
    chk({req, " ret_src"}, ret_src, src);
    if (blk) begin
      chk({req, " ret_pc"}, ret_pc, 32'h1000 + id);
      chk({req, " ret_sp"}, ret_sp, 32'h8000 + id);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0;
    tick();
    // R1
    chk("R1 enq_ready", enq_ready, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 ret_valid", ret_valid, 0);

    // table walk: fill, priority order, tie order (R4 R5)
    for (int r = 0; r < 4; r++) enq(T_ID[r], T_SRC[r], T_PRIO[r]);
    chk("R2 full enq_ready", enq_ready, 0);
    enq(99, 0, 500);  // R2 offered while full: must be discarded
    for (int k = 0; k < 4; k++) begin
      issue("R4 R5 order", T_ID[T_ORD[k]], T_SRC[T_ORD[k]]);
      tick();
      chk("R6 one pulse", iss_valid, 0);
      finish_run("R7 done", 0, T_ID[T_ORD[k]], T_SRC[T_ORD[k]]);
      if (k == 0) chk("R11 ready after free", enq_ready, 1);
    end
    lc_idle = 1; tick(); tick(); lc_idle = 0;
    chk("R2 discarded request not issued", iss_valid, 0);

    // R10 stray end signals
    lc_done = 1; tick(); lc_done = 0;
    chk("R10 stray done", ret_valid, 0);
    lc_block = 1; tick(); lc_block = 0;
    chk("R10 stray block", ret_valid, 0);

    // R9 keyed update of duplicate ids, R8 send-back
    enq(20, 0, 3);
    enq(21, 1, 4);
    enq(20, 2, 3);
    upd_valid = 1; upd_id = 20; upd_prio = 7; tick(); upd_valid = 0;
    issue("R9 updated first", 20, 0);
    lc_idle = 1; tick(); lc_idle = 0;
    chk("R6 no issue while running", iss_valid, 0);
    finish_run("R8 blocked", 1, 20, 0);
    issue("R9 duplicate updated", 20, 2);
    finish_run("R7 done", 0, 20, 2);
    issue("R4 remaining", 21, 1);
    finish_run("R8 blocked", 1, 21, 1);
    chk("R11 empty ready", enq_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule